// File: doc/BRIEF.md
# Sequencer Command Mailbox Register Block

This block is a small memory-mapped register file between a host CPU bus and a memory-subsystem sequencer. The host first loads up to seven parameter words. It then writes a non-zero command request word. While the request word is non-zero, the block offers the command to the sequencer through a valid/ready handshake. The request register clears itself on the cycle the sequencer accepts the command, so a request register that reads zero tells the host that the mailbox is free.

When the sequencer returns a result, the block captures it in a single cycle: a response status word (ready flag, two error codes and a 16-bit short data value) and three response data words. The host polls the ready flag, reads the results, and then clears the flag with a read-modify-write that zeroes bit 0. A request written while the mailbox is busy or while a result is still unread is dropped, and a sticky overrun bit records the loss.

Top module: `cmd_mailbox_regs`

## Requirements
- R1: After reset every register reads zero and `cmd_valid` is low.
- R2: Parameter word i (i = 0..6) is written and read at byte offset 0x438 - 4*i. It keeps its value across commands and is presented on `cmd_params[32*i +: 32]`.
- R3: A write of a non-zero word to the request register at 0x43C, made while the mailbox is idle (request register zero and ready flag clear), raises `cmd_valid` from the next cycle with `cmd_word` equal to the written word. The word is packed as IP type [31:29], instance ID [28:24], command type [23:16] and opcode [15:0].
- R4: The request register holds its value and `cmd_valid` stays high until a cycle in which `cmd_ready` is high. After that cycle the request register reads zero and `cmd_valid` is low.
- R5: A cycle with `resp_valid` high captures the response in one cycle. The status word at 0x45C then reads ready = bit 0, general error = bits 4:1, command error = bits 7:5 and short data = bits 31:16. Response data 0, 1 and 2 read at 0x458, 0x454 and 0x450.
- R6: A write to the status word with bit 0 = 0 clears the ready flag. A write with bit 0 = 1 leaves the flag set. The error and short data fields are never changed by a host write.
- R7: A non-zero request written while the request register is non-zero or the ready flag is set is ignored, and it sets the sticky overrun flag at status bit 8. Only a status write with bit 8 = 0 clears that flag.
- R8: A write of zero to the request register while the mailbox is idle launches nothing and leaves the request register at zero.
- R9: A read of an address that maps to no register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for bus_addr (combinational) |
| cmd_valid | output | 1 | Command offered to the sequencer |
| cmd_ready | input | 1 | Sequencer accepts the command |
| cmd_word | output | 32 | Packed request word |
| cmd_params | output | 32*NPARAM | Parameter words, word i in bits 32*i+31:32*i |
| resp_valid | input | 1 | Sequencer result strobe |
| resp_short | input | 16 | Short response data |
| resp_cmd_err | input | 3 | Command response error code |
| resp_gen_err | input | 4 | General error code |
| resp_data | input | 32*NDATA | Response data words, word i in bits 32*i+31:32*i |

## Verification
A stuck or wrongly cleared request register shows up at the ports at once. `cmd_valid` would stay high after an accept, or drop before one, and a read of 0x43C on the following cycle would return the wrong busy indication. A wrong ready or overrun state appears on the next status read after the response strobe or the host write that should have changed it. A capture into the wrong field shows up as a misplaced bit in the status word or as swapped data offsets, on the first read after `resp_valid`. The busy protection is checked by sending requests that collide with a pending command and with an unread result, and then confirming that `cmd_word` is unchanged and that the overrun bit is set.

// File: rtl/cmd_mailbox_regs.sv
`timescale 1ns/1ps
module cmd_mailbox_regs #(
  parameter int ADDR_W = 12,
  parameter int NPARAM = 7,
  parameter int NDATA  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic [31:0]           cmd_word,
  output logic [32*NPARAM-1:0]  cmd_params,
  input  logic                  resp_valid,
  input  logic [15:0]           resp_short,
  input  logic [2:0]            resp_cmd_err,
  input  logic [3:0]            resp_gen_err,
  input  logic [32*NDATA-1:0]   resp_data
);
  localparam int PAR_TOP  = 'h438;
  localparam int DAT_TOP  = 'h458;
  localparam logic [ADDR_W-1:0] REQ_ADDR  = ADDR_W'('h43C);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'('h45C);
  localparam int RDY_BIT = 0;
  localparam int OVR_BIT = 8;

  logic [31:0] par_q [NPARAM];
  logic [31:0] dat_q [NDATA];
  logic [31:0] req_q;
  logic        rdy_q, ovr_q;
  logic [15:0] short_q;
  logic [2:0]  cerr_q;
  logic [3:0]  gerr_q;

  wire req_wr   = bus_wr && bus_addr == REQ_ADDR;
  wire stat_wr  = bus_wr && bus_addr == STAT_ADDR;
  wire busy     = (req_q != 32'd0) || rdy_q;
  wire accept   = cmd_valid && cmd_ready;
  wire collide  = req_wr && bus_wdata != 32'd0 && busy;

  assign cmd_valid = req_q != 32'd0;
  assign cmd_word  = req_q;

  for (genvar i = 0; i < NPARAM; i++) begin : g_par
    localparam logic [ADDR_W-1:0] A = ADDR_W'(PAR_TOP - 4*i);
    always_ff @(posedge clk) begin
      if (!rst_n) par_q[i] <= '0;
      else if (bus_wr && bus_addr == A) par_q[i] <= bus_wdata;
    end
    assign cmd_params[32*i +: 32] = par_q[i];
  end

  for (genvar i = 0; i < NDATA; i++) begin : g_dat
    always_ff @(posedge clk) begin
      if (!rst_n) dat_q[i] <= '0;
      else if (resp_valid) dat_q[i] <= resp_data[32*i +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else if (accept) req_q <= '0;
    else if (req_wr && !busy) req_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0; ovr_q <= 1'b0;
      short_q <= '0; cerr_q <= '0; gerr_q <= '0;
    end else begin
      if (resp_valid) begin
        rdy_q   <= 1'b1;
        short_q <= resp_short;
        cerr_q  <= resp_cmd_err;
        gerr_q  <= resp_gen_err;
      end else if (stat_wr && !bus_wdata[RDY_BIT]) begin
        rdy_q <= 1'b0;
      end
      if (collide) ovr_q <= 1'b1;
      else if (stat_wr && !bus_wdata[OVR_BIT]) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == REQ_ADDR) bus_rdata = req_q;
    if (bus_addr == STAT_ADDR)
      bus_rdata = {short_q, 7'd0, ovr_q, cerr_q, gerr_q, rdy_q};
    for (int i = 0; i < NPARAM; i++)
      if (bus_addr == ADDR_W'(PAR_TOP - 4*i)) bus_rdata = par_q[i];
    for (int i = 0; i < NDATA; i++)
      if (bus_addr == ADDR_W'(DAT_TOP - 4*i)) bus_rdata = dat_q[i];
  end

  // R4: accepted command is withdrawn on the next cycle
  a_r4_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);
  // R4: an unaccepted command is held unchanged
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word));
  // R5: a result strobe sets the ready flag
  a_r5_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> rdy_q);
  // R7: a colliding request sets overrun and does not change the command
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr && bus_wdata != 32'd0 && (cmd_valid || rdy_q) && !cmd_ready
    |=> ovr_q && $stable(cmd_word));
  // R7: overrun stays set until a status write with bit 8 = 0
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !(stat_wr && !bus_wdata[OVR_BIT]) |=> ovr_q);
  // R8: a zero request written while idle launches nothing
  a_r8_zero_noop: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr && bus_wdata == 32'd0 && !cmd_valid |=> !cmd_valid);
endmodule

// File: tb/test_cmd_mailbox_regs.sv
`timescale 1ns/1ps
module test_cmd_mailbox_regs;
  localparam int ADDR_W = 12;
  localparam int NPARAM = 7;
  localparam int NDATA  = 3;
  localparam logic [ADDR_W-1:0] REQ  = 12'h43C;
  localparam logic [ADDR_W-1:0] STAT = 12'h45C;

  logic clk = 0, rst_n = 0, bus_wr = 0, cmd_ready = 0, resp_valid = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, cmd_word;
  logic cmd_valid;
  logic [32*NPARAM-1:0] cmd_params;
  logic [15:0] resp_short = '0;
  logic [2:0] resp_cmd_err = '0;
  logic [3:0] resp_gen_err = '0;
  logic [32*NDATA-1:0] resp_data = '0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cmd_mailbox_regs #(.ADDR_W(ADDR_W), .NPARAM(NPARAM), .NDATA(NDATA)) i_cmd_mailbox_regs (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .cmd_valid, .cmd_ready, .cmd_word, .cmd_params,
    .resp_valid, .resp_short, .resp_cmd_err, .resp_gen_err, .resp_data);

  localparam logic [ADDR_W-1:0] VA [7] = '{12'h438, 12'h434, 12'h430, 12'h42C, 12'h428, 12'h424, 12'h420};
  localparam logic [31:0]       VD [7] = '{32'h00000040, 32'hDEADBEEF, 32'h12345678, 32'hFFFFFFFF,
                                           32'h80000001, 32'h0F0F0F0F, 32'hA5A5A5A5};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic accept();
    @(negedge clk); cmd_ready = 1;
    @(negedge clk); cmd_ready = 0;
  endtask

  task automatic respond(input logic [15:0] s, input logic [2:0] ce, input logic [3:0] ge,
                         input logic [95:0] d);
    @(negedge clk); resp_valid = 1; resp_short = s; resp_cmd_err = ce; resp_gen_err = ge; resp_data = d;
    @(negedge clk); resp_valid = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(REQ, r);  chk("R1 request", r, 0);
    rd(STAT, r); chk("R1 status", r, 0);
    rd(12'h438, r); chk("R1 param0", r, 0);
    chk("R1 cmd_valid", {31'd0, cmd_valid}, 0);

    // R2 parameter table
    for (int i = 0; i < 7; i++) wr(VA[i], VD[i]);
    for (int i = 0; i < 7; i++) begin
      rd(VA[i], r); chk("R2 param readback", r, VD[i]);
      chk("R2 param output", cmd_params[32*i +: 32], VD[i]);
    end

    // R8 zero request while idle
    wr(REQ, 0);
    chk("R8 no launch", {31'd0, cmd_valid}, 0);
    rd(REQ, r); chk("R8 request stays zero", r, 0);

    // R3 launch
    wr(REQ, {3'd1, 5'd2, 8'h20, 16'h0004});
    chk("R3 cmd_valid", {31'd0, cmd_valid}, 1);
    chk("R3 cmd_word", cmd_word, 32'h22200004);
    // R4 hold while not accepted
    @(negedge clk);
    rd(REQ, r); chk("R4 busy reads nonzero", r, 32'h22200004);
    // R7 collision while busy
    wr(REQ, 32'h11111111);
    chk("R7 word unchanged", cmd_word, 32'h22200004);
    rd(STAT, r); chk("R7 overrun set", r, 32'h100);
    accept();
    chk("R4 valid drops", {31'd0, cmd_valid}, 0);
    rd(REQ, r); chk("R4 request cleared", r, 0);

    // R5 capture
    respond(16'hBEEF, 3'd5, 4'hA, {32'hCCCC0002, 32'hBBBB0001, 32'hAAAA0000});
    rd(STAT, r); chk("R5 status fields", r, {16'hBEEF, 7'd0, 1'b1, 3'd5, 4'hA, 1'b1});
    rd(12'h458, r); chk("R5 data0", r, 32'hAAAA0000);
    rd(12'h454, r); chk("R5 data1", r, 32'hBBBB0001);
    rd(12'h450, r); chk("R5 data2", r, 32'hCCCC0002);

    // R7 collision with unread result
    wr(REQ, 32'h00000001);
    chk("R7 ignored while ready", {31'd0, cmd_valid}, 0);

    // R6 write 1 to bit0 keeps flag, write 0 clears; fields unchanged
    wr(STAT, 32'h00000101);
    rd(STAT, r); chk("R6 bit0=1 keeps ready", r, {16'hBEEF, 7'd0, 1'b1, 3'd5, 4'hA, 1'b1});
    wr(STAT, 32'h00000100);
    rd(STAT, r); chk("R6 ready cleared overrun kept", r, {16'hBEEF, 7'd0, 1'b1, 3'd5, 4'hA, 1'b0});
    wr(STAT, 32'h00000001);
    rd(STAT, r); chk("R7 overrun cleared", r, {16'hBEEF, 7'd0, 1'b0, 3'd5, 4'hA, 1'b0});

    // R2 params retained; second command launches with them
    wr(REQ, 32'hE1000007);
    chk("R3 second launch", cmd_word, 32'hE1000007);
    chk("R2 params retained", cmd_params[32*1 +: 32], 32'hDEADBEEF);
    accept();
    rd(REQ, r); chk("R4 second clear", r, 0);

    // R9 unmapped
    rd(12'h440, r); chk("R9 unmapped", r, 0);
    rd(12'h000, r); chk("R9 unmapped low", r, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule